// File: doc/BRIEF.md
# Video Capture Port with 2:1 Decimator

This block takes in a byte-serial 4:2:2 component video stream, one byte per pixel-clock enable. Each pixel pair arrives as four bytes: blue-difference chroma, first luma, red-difference chroma, second luma. The block can drop every second pixel pair to halve the horizontal resolution. It packs the bytes it keeps into 64-bit words, two pixel pairs per word, and writes each word into an off-screen region of the frame buffer. The write port is a plain request/acknowledge port.

Line and field timing comes from one of two sources. The block can count active width, blanking and line totals itself and drive its own horizontal blanking and field indicator outputs. It can also follow an external active-line qualifier and an external field level. Capture works in whole fields or in whole frames. In frame mode the two fields are woven line by line into the buffer. A sticky interrupt is raised each time a field capture, or a frame capture, has been stored.

Top module: `vcap_port`

## Requirements
- R1: After reset `wr_req`, `irq`, `hs_out` and `field_out` are all 0.
- R2: Kept bytes are packed little-endian: the k-th kept byte of a line sits at bits [8(k mod 8)+7 : 8(k mod 8)] of word k/8. Word w of capture line L goes to `cfg_base + L*cfg_stride + 8*w` in field mode.
- R3: When a line ends with a partly filled word, that word is written with its unfilled upper bytes set to zero.
- R4: With `cfg_decim` set, the bytes of odd pixel pairs within a line (pair index = byte index / 4) are discarded and the even pairs are packed back to back.
- R5: In frame mode a capture starts only at a change to field 0. Field 0 lines go to `cfg_base + 2k*cfg_stride` and the following field 1 lines go to `cfg_base + (2k+1)*cfg_stride`. No interrupt is raised between the two fields.
- R6: A field-level change starts a capture if `cfg_enable` is set (frame mode additionally needs field 0). It also ends the running capture: in field mode after one field, in frame mode after the second field. Ending a capture sets `irq`.
- R7: `irq` stays high until a cycle with `irq_clr` high, and is low the cycle after that.
- R8: While `cfg_enable` is low, a running capture still completes, but no new capture starts and no writes are issued.
- R9: Once raised, `wr_req` holds with `wr_addr` and `wr_data` unchanged until the cycle in which `wr_ack` is high.
- R10: With internal timing, byte position h counts enabled bytes modulo `4*cfg_pairs + HBLANK`. Bytes with h < `4*cfg_pairs` on the first `cfg_lines` lines are active. `hs_out` is high while h >= `4*cfg_pairs`. `field_out` toggles after every `cfg_lines + VBLANK` lines.
- R11: With `cfg_ext_sync` set, `hs_out` and `field_out` are held at 0, and only bytes presented while `ext_href` is high are captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Allows new captures to start |
| cfg_ext_sync | input | 1 | 1: follow external timing, 0: generate timing |
| cfg_decim | input | 1 | 1: keep only even pixel pairs |
| cfg_frame | input | 1 | 1: frame capture, 0: field capture |
| cfg_pairs | input | PW | Active pixel pairs per line (internal timing) |
| cfg_lines | input | LW | Active lines per field (internal timing) |
| cfg_base | input | AW | Byte address of the capture region |
| cfg_stride | input | AW | Byte distance between buffer lines |
| irq_clr | input | 1 | Clears the interrupt flag |
| vin_valid | input | 1 | A video byte is present this cycle |
| vin_data | input | 8 | Video byte |
| ext_href | input | 1 | External active-line qualifier |
| ext_field | input | 1 | External field level |
| hs_out | output | 1 | Generated horizontal blanking |
| field_out | output | 1 | Generated field indicator |
| wr_req | output | 1 | Write request |
| wr_ack | input | 1 | Write accepted |
| wr_addr | output | AW | Write byte address |
| wr_data | output | 64 | Write data |
| irq | output | 1 | Capture-complete interrupt |

## Verification
The assertions take for granted that `cfg_base` and `cfg_stride` are multiples of eight, and that the write port acknowledges each word before the next one is complete. The bench's acknowledge latency of two cycles is well inside the eight-byte spacing between words, and every line it sends is long enough to leave room for a flush. The assertions also assume that with external timing a field change never falls in the same cycle as a line end or an active byte. The bench therefore leaves idle cycles around every field change, changes modes only between captures or across a reset, and changes `cfg_decim` only between lines.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

    localparam int WORD_BYTES = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic take;
        logic line_end;
        logic field_evt;
        logic field;
    } tim_evt_t;

endpackage

// File: rtl/vcap_timing.sv
module vcap_timing
    import vcap_pkg::*;
#(
    parameter int PW     = 10,
    parameter int LW     = 10,
    parameter int HBLANK = 8,
    parameter int VBLANK = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_sync,
    input  logic          vin_valid,
    input  logic          ext_href,
    input  logic          ext_field,
    input  logic [PW-1:0] cfg_pairs,
    input  logic [LW-1:0] cfg_lines,
    output tim_evt_t      evt,
    output logic          hs_out,
    output logic          field_out
);
    localparam int HW = PW + 3;
    localparam int VW = LW + 1;

    typedef struct packed {
        logic [HW-1:0] hcnt;
        logic [VW-1:0] vcnt;
        logic          field;
        logic          act_prev;
        logic          field_prev;
    } tim_state_t;

    tim_state_t st_q, st_d;

    logic [HW-1:0] h_act_len;
    logic [HW-1:0] h_tot;
    logic [VW-1:0] v_tot;
    logic          gen_act;
    logic          act_lvl;
    logic          fld_lvl;

    always_comb begin
        h_act_len = HW'({cfg_pairs, 2'b00});
        h_tot     = h_act_len + HW'(HBLANK);
        v_tot     = VW'(cfg_lines) + VW'(VBLANK);
        gen_act   = (st_q.hcnt < h_act_len) && (st_q.vcnt < VW'(cfg_lines));
        act_lvl   = ext_sync ? ext_href  : gen_act;
        fld_lvl   = ext_sync ? ext_field : st_q.field;

        evt.take      = vin_valid & act_lvl;
        evt.line_end  = st_q.act_prev & ~act_lvl;
        evt.field_evt = fld_lvl ^ st_q.field_prev;
        evt.field     = fld_lvl;

        st_d            = st_q;
        st_d.act_prev   = act_lvl;
        st_d.field_prev = fld_lvl;
        if (!ext_sync && vin_valid) begin
            if (st_q.hcnt == h_tot - HW'(1)) begin
                st_d.hcnt = '0;
                if (st_q.vcnt == v_tot - VW'(1)) begin
                    st_d.vcnt  = '0;
                    st_d.field = ~st_q.field;
                end else begin
                    st_d.vcnt = st_q.vcnt + VW'(1);
                end
            end else begin
                st_d.hcnt = st_q.hcnt + HW'(1);
            end
        end

        hs_out    = !ext_sync && (st_q.hcnt >= h_act_len);
        field_out = !ext_sync && st_q.field;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vcap_capture.sv
module vcap_capture
    import vcap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  tim_evt_t      evt,
    input  logic          cfg_enable,
    input  logic          cfg_decim,
    input  logic          cfg_frame,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_stride,
    input  logic [7:0]    vin_data,
    input  logic          irq_clr,
    input  logic          wr_ack,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [63:0]   wr_data,
    output logic          irq
);
    localparam int WB   = $clog2(WORD_BYTES);
    localparam int DW   = WORD_BYTES * 8;

    typedef struct packed {
        cap_state_e    st;
        logic          frame;
        logic [AW-1:0] line_addr;
        logic [AW-1:0] word_off;
        logic [WB-1:0] bidx;
        logic [1:0]    phase;
        logic          odd;
        logic [DW-1:0] acc;
        logic          req;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          irq;
    } cap_state_t;

    cap_state_t cs_q, cs_d;
    logic       set_irq;
    logic       keep;

    always_comb begin
        cs_d    = cs_q;
        set_irq = 1'b0;
        keep    = 1'b0;

        if (cs_q.req && wr_ack) begin
            cs_d.req = 1'b0;
        end

        if (evt.field_evt) begin
            cs_d.word_off = '0;
            cs_d.bidx     = '0;
            cs_d.phase    = '0;
            cs_d.odd      = 1'b0;
            cs_d.acc      = '0;
            case (cs_q.st)
                ST_FIRST: begin
                    if (cs_q.frame) begin
                        cs_d.st        = ST_SECOND;
                        cs_d.line_addr = cfg_base + cfg_stride;
                    end else begin
                        cs_d.st = ST_IDLE;
                        set_irq = 1'b1;
                    end
                end
                ST_SECOND: begin
                    cs_d.st = ST_IDLE;
                    set_irq = 1'b1;
                end
                default: cs_d.st = ST_IDLE;
            endcase
            if (cs_d.st == ST_IDLE && cfg_enable && (!cfg_frame || !evt.field)) begin
                cs_d.st        = ST_FIRST;
                cs_d.frame     = cfg_frame;
                cs_d.line_addr = cfg_base;
            end
        end

        if (evt.line_end && cs_d.st != ST_IDLE) begin
            if (cs_d.bidx != '0) begin
                cs_d.req  = 1'b1;
                cs_d.addr = cs_d.line_addr + cs_d.word_off;
                cs_d.data = cs_d.acc;
            end
            cs_d.line_addr = cs_d.line_addr +
                             (cs_d.frame ? {cfg_stride[AW-2:0], 1'b0} : cfg_stride);
            cs_d.word_off  = '0;
            cs_d.bidx      = '0;
            cs_d.phase     = '0;
            cs_d.odd       = 1'b0;
            cs_d.acc       = '0;
        end

        if (evt.take && cs_d.st != ST_IDLE) begin
            keep = !(cfg_decim && cs_d.odd);
            if (keep) begin
                cs_d.acc[{cs_d.bidx, 3'b000} +: 8] = vin_data;
                if (cs_d.bidx == WB'(WORD_BYTES - 1)) begin
                    cs_d.req      = 1'b1;
                    cs_d.addr     = cs_d.line_addr + cs_d.word_off;
                    cs_d.data     = cs_d.acc;
                    cs_d.word_off = cs_d.word_off + AW'(WORD_BYTES);
                    cs_d.acc      = '0;
                end
                cs_d.bidx = cs_d.bidx + WB'(1);
            end
            if (cs_d.phase == 2'd3) begin
                cs_d.odd = ~cs_d.odd;
            end
            cs_d.phase = cs_d.phase + 2'd1;
        end

        cs_d.irq = (cs_q.irq & ~irq_clr) | set_irq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= '0;
            cs_q.st <= ST_IDLE;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign wr_req  = cs_q.req;
    assign wr_addr = cs_q.addr;
    assign wr_data = cs_q.data;
    assign irq     = cs_q.irq;

endmodule

// File: rtl/vcap_port.sv
module vcap_port
    import vcap_pkg::*;
#(
    parameter int AW     = 32,
    parameter int PW     = 10,
    parameter int LW     = 10,
    parameter int HBLANK = 8,
    parameter int VBLANK = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_enable,
    input  logic          cfg_ext_sync,
    input  logic          cfg_decim,
    input  logic          cfg_frame,
    input  logic [PW-1:0] cfg_pairs,
    input  logic [LW-1:0] cfg_lines,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_stride,
    input  logic          irq_clr,
    input  logic          vin_valid,
    input  logic [7:0]    vin_data,
    input  logic          ext_href,
    input  logic          ext_field,
    output logic          hs_out,
    output logic          field_out,
    output logic          wr_req,
    input  logic          wr_ack,
    output logic [AW-1:0] wr_addr,
    output logic [63:0]   wr_data,
    output logic          irq
);
    tim_evt_t evt;

    vcap_timing #(
        .PW     (PW),
        .LW     (LW),
        .HBLANK (HBLANK),
        .VBLANK (VBLANK)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sync  (cfg_ext_sync),
        .vin_valid (vin_valid),
        .ext_href  (ext_href),
        .ext_field (ext_field),
        .cfg_pairs (cfg_pairs),
        .cfg_lines (cfg_lines),
        .evt       (evt),
        .hs_out    (hs_out),
        .field_out (field_out)
    );

    vcap_capture #(
        .AW (AW)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .cfg_enable (cfg_enable),
        .cfg_decim  (cfg_decim),
        .cfg_frame  (cfg_frame),
        .cfg_base   (cfg_base),
        .cfg_stride (cfg_stride),
        .vin_data   (vin_data),
        .irq_clr    (irq_clr),
        .wr_ack     (wr_ack),
        .wr_req     (wr_req),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .irq        (irq)
    );

endmodule

// File: rtl/vcap_port_chk.sv
module vcap_port_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_ext_sync,
    input logic          ext_field,
    input logic          irq_clr,
    input logic          hs_out,
    input logic          field_out,
    input logic          wr_req,
    input logic          wr_ack,
    input logic [AW-1:0] wr_addr,
    input logic [63:0]   wr_data,
    input logic          irq
);
    logic fld_seen;
    assign fld_seen = cfg_ext_sync ? ext_field : field_out;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data)); // R9

    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_addr[2:0] == 3'd0); // R2

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq); // R7

    AST_IRQ_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fld_seen, 1) != $past(fld_seen, 2)); // R6

    AST_EXT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ext_sync |-> !hs_out && !field_out); // R11

endmodule

bind vcap_port vcap_port_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_ext_sync (cfg_ext_sync),
    .ext_field    (ext_field),
    .irq_clr      (irq_clr),
    .hs_out       (hs_out),
    .field_out    (field_out),
    .wr_req       (wr_req),
    .wr_ack       (wr_ack),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .irq          (irq)
);

// File: tb/tb_vcap_port.sv
`timescale 1ns/1ps
module tb_vcap_port;
    localparam int AW = 32;
    localparam int PW = 10;
    localparam int LW = 10;
    localparam int HB = 8;
    localparam int VB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_enable = 1'b0;
    logic          cfg_ext_sync = 1'b1;
    logic          cfg_decim = 1'b0;
    logic          cfg_frame = 1'b0;
    logic [PW-1:0] cfg_pairs = '0;
    logic [LW-1:0] cfg_lines = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_stride = '0;
    logic          irq_clr = 1'b0;
    logic          vin_valid = 1'b0;
    logic [7:0]    vin_data = '0;
    logic          ext_href = 1'b0;
    logic          ext_field = 1'b0;
    logic          hs_out, field_out, wr_req, irq;
    logic          wr_ack = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [63:0]   wr_data;

    vcap_port #(.AW(AW), .PW(PW), .LW(LW), .HBLANK(HB), .VBLANK(VB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_ext_sync(cfg_ext_sync),
        .cfg_decim(cfg_decim), .cfg_frame(cfg_frame), .cfg_pairs(cfg_pairs),
        .cfg_lines(cfg_lines), .cfg_base(cfg_base), .cfg_stride(cfg_stride),
        .irq_clr(irq_clr), .vin_valid(vin_valid), .vin_data(vin_data),
        .ext_href(ext_href), .ext_field(ext_field), .hs_out(hs_out),
        .field_out(field_out), .wr_req(wr_req), .wr_ack(wr_ack),
        .wr_addr(wr_addr), .wr_data(wr_data), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model state
    int            m_st = 0;
    bit            m_frame = 1'b0;
    bit            m_half = 1'b0;
    int            m_line = 0;
    bit            exp_irq = 1'b0;
    logic [AW-1:0] exp_addr[$];
    logic [63:0]   exp_data[$];
    string         exp_tag[$];
    int            pend = 0;
    logic [AW-1:0] held_addr;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic wrap_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic model_field(input bit f);
        if (m_st == 1) begin
            if (m_frame) begin m_st = 2; m_half = 1'b1; m_line = 0; end
            else begin m_st = 0; exp_irq = 1'b1; end
        end else if (m_st == 2) begin
            m_st = 0; exp_irq = 1'b1;
        end
        if (m_st == 0 && cfg_enable && (!cfg_frame || !f)) begin
            m_st = 1; m_frame = cfg_frame; m_half = 1'b0; m_line = 0;
        end
    endtask

    task automatic model_line(input logic [7:0] bytes[$], input string tag);
        logic [7:0] kept[$];
        longint off;
        if (m_st == 0) return;
        for (int i = 0; i < bytes.size(); i++)
            if (!cfg_decim || ((i / 4) % 2 == 0)) kept.push_back(bytes[i]);
        off = m_frame ? (2 * m_line + int'(m_half)) * longint'(cfg_stride)
                      : m_line * longint'(cfg_stride);
        for (int w = 0; w < (kept.size() + 7) / 8; w++) begin
            logic [63:0] d;
            d = '0;
            for (int k = 0; k < 8; k++)
                if (w * 8 + k < kept.size()) d[8*k +: 8] = kept[w * 8 + k];
            exp_addr.push_back(AW'(longint'(cfg_base) + off + 8 * w));
            exp_data.push_back(d);
            exp_tag.push_back(tag);
        end
        m_line++;
    endtask

    // write port responder and scoreboard, acts on falling edges
    always @(negedge clk) begin
        if (wr_ack) begin
            wr_ack = 1'b0;
            pend = 0;
        end else if (wr_req) begin
            if (pend >= 1) begin
                chk(wr_addr == held_addr, "R9", "address moved while pending",
                    longint'(wr_addr), longint'(held_addr));
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R8", "write not expected", longint'(wr_addr), 0);
                end else begin
                    string t;
                    logic [AW-1:0] ea;
                    logic [63:0] ed;
                    t = exp_tag.pop_front();
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    chk(wr_addr == ea, t, "write address", longint'(wr_addr), longint'(ea));
                    chk(wr_data == ed, t, "write data", longint'(wr_data), longint'(ed));
                end
                wr_ack = 1'b1;
            end else begin
                held_addr = wr_addr;
                pend++;
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            vin_valid = 1'b0;
            ext_href  = 1'b0;
        end
    endtask

    task automatic ext_line(input int nbytes, input int seed, input string tag);
        logic [7:0] bytes[$];
        for (int i = 0; i < nbytes; i++) bytes.push_back(8'(seed * 16 + i * 7 + 1));
        model_line(bytes, tag);
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            vin_valid = 1'b1;
            ext_href  = 1'b1;
            vin_data  = bytes[i];
        end
        idle(4);
    endtask

    task automatic ext_fld(input bit f, input string tag);
        @(negedge clk);
        ext_field = f;
        model_field(f);
        idle(4);
        chk(irq == exp_irq, tag, "irq after field change", longint'(irq), longint'(exp_irq));
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_clr = 1'b1;
        exp_irq = 1'b0;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq == 1'b0, "R7", "irq after clear", longint'(irq), 0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_st = 0; exp_irq = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            wrap_up();
        end
    end

    initial begin
        do_reset();
        chk(wr_req == 1'b0, "R1", "wr_req after reset", longint'(wr_req), 0);
        chk(irq == 1'b0, "R1", "irq after reset", longint'(irq), 0);
        chk(hs_out == 1'b0, "R1", "hs_out after reset", longint'(hs_out), 0);
        chk(field_out == 1'b0, "R1", "field_out after reset", longint'(field_out), 0);

        // external timing, field capture
        cfg_ext_sync = 1'b1; cfg_enable = 1'b1; cfg_decim = 1'b0; cfg_frame = 1'b0;
        cfg_base = 32'h1000; cfg_stride = 32'h200;
        ext_fld(1'b1, "R6");
        ext_line(16, 1, "R2");
        chk(hs_out == 1'b0 && field_out == 1'b0, "R11", "generated sync quiet",
            longint'({hs_out, field_out}), 0);
        ext_line(12, 2, "R3");
        ext_line(20, 3, "R3");
        ext_fld(1'b0, "R6");
        idle(5);
        chk(irq == 1'b1, "R7", "irq stays set", longint'(irq), 1);
        clear_irq();

        // decimation
        cfg_decim = 1'b1;
        ext_line(16, 4, "R4");
        ext_line(24, 5, "R4");
        ext_line(8, 6, "R4");
        ext_fld(1'b1, "R6");
        clear_irq();

        // frame capture with interleave
        cfg_decim = 1'b0; cfg_frame = 1'b1;
        ext_fld(1'b0, "R6");
        clear_irq();
        ext_line(8, 7, "R5");
        ext_line(8, 8, "R5");
        ext_fld(1'b1, "R5");
        ext_line(8, 9, "R5");
        ext_line(16, 10, "R5");
        ext_fld(1'b0, "R5");
        clear_irq();

        // enable cleared: running frame completes, nothing new
        cfg_enable = 1'b0;
        ext_line(8, 11, "R8");
        ext_fld(1'b1, "R8");
        ext_line(8, 12, "R8");
        ext_fld(1'b0, "R8");
        clear_irq();
        ext_line(8, 13, "R8");
        ext_fld(1'b1, "R8");
        ext_line(8, 14, "R8");
        ext_fld(1'b0, "R8");

        // frame mode does not start on field 1
        cfg_enable = 1'b1;
        ext_fld(1'b1, "R5");
        ext_line(8, 15, "R5");
        ext_fld(1'b0, "R5");
        ext_line(8, 16, "R5");
        ext_fld(1'b1, "R5");
        ext_line(12, 17, "R5");
        ext_fld(1'b0, "R6");
        idle(8);
        chk(exp_addr.size() == 0, "R2", "writes outstanding (external)",
            longint'(exp_addr.size()), 0);

        // internal timing
        cfg_enable = 1'b0; cfg_frame = 1'b0; cfg_decim = 1'b0;
        cfg_ext_sync = 1'b0; cfg_pairs = PW'(4); cfg_lines = LW'(3);
        cfg_base = 32'h8000; cfg_stride = 32'h100;
        do_reset();
        cfg_enable = 1'b1;
        begin
            int htot, ftot, nbytes;
            logic [7:0] lb[$];
            htot = 4 * 4 + HB;
            ftot = htot * (3 + VB);
            nbytes = 2 * ftot + 3 * htot;
            for (int n = 0; n < nbytes; n++) begin
                int h, v;
                h = n % htot;
                v = (n / htot) % (3 + VB);
                if (h == 0 && v == 0 && n > 0) model_field(bit'((n / ftot) % 2));
                if (v < 3 && h < 16) lb.push_back(8'(n));
                if (v < 3 && h == 15) begin
                    model_line(lb, "R10");
                    lb.delete();
                end
            end
            for (int n = 0; n < nbytes; n++) begin
                @(negedge clk);
                chk(hs_out == ((n % htot) >= 16), "R10", "hs_out",
                    longint'(hs_out), longint'((n % htot) >= 16));
                chk(field_out == bit'((n / ftot) % 2), "R10", "field_out",
                    longint'(field_out), longint'((n / ftot) % 2));
                vin_valid = 1'b1;
                vin_data  = 8'(n);
            end
            idle(8);
        end
        chk(irq == exp_irq, "R6", "irq with internal timing", longint'(irq), longint'(exp_irq));
        chk(exp_addr.size() == 0, "R10", "writes outstanding (internal)",
            longint'(exp_addr.size()), 0);
        done = 1'b1;
        wrap_up();
    end

endmodule